// File: doc/BRIEF.md
# Multi-Unit Issue Interlock Scoreboard

This block decides, cycle by cycle, whether the decoded instruction waiting at the head of an in-order, single-issue pipeline may leave for execution. The pipeline behind it has three execution resources: an integer path (which also carries loads), a floating-point adder and a floating-point multiplier. Work in all three may overlap, but neither floating-point unit is pipelined internally. A new operation for a unit that is still occupied therefore has to wait until that unit is free.

Each cycle the front end presents one instruction: its class, up to two source register numbers with use flags, and a destination. The block keeps a countdown of remaining occupancy for each floating-point unit and a countdown for each register that has a result in flight. It raises `issue` when no hazard applies and `stall` otherwise. A stalled instruction stays on the inputs until it issues. The block also reports every register writeback as a one-cycle pulse on a single write port that the three units share. The integer path has first claim on that port.

Class codes on `instClass`: 0 no-op, 1 integer, 2 load, 3 double-precision add, 4 single-precision multiply, 5 double-precision multiply. Codes 6 and 7 act as no-ops. Writeback unit codes on `wbUnit`: 0 none, 1 integer path, 2 adder, 3 multiplier.

Top module: `fp_issue_interlock`

## Requirements
- R1: A synchronous reset clears every unit-occupancy counter and every register-pending counter. In the first cycle after reset, `wbValid` is 0 and an integer instruction issues with no stall.
- R2: `issue` is never high without `instValid`, and `stall` is high exactly when `instValid` is high and the instruction does not issue.
- R3: A double add (class 3) holds the adder for 4 cycles. A second add issued at cycle t may issue no earlier than t+4.
- R4: A single multiply (class 4) holds the multiplier for 6 cycles and a double multiply (class 5) holds it for 8 cycles. The next multiply waits until that many cycles have passed.
- R5: Independent integer, add and multiply instructions issue in consecutive cycles with no stall.
- R6: When an instruction reads the destination of a load (class 2) issued at cycle t, it stalls in cycles t+1 and t+2 and issues at t+3.
- R7: A reader of a floating-point destination issues no earlier than the cycle in which that unit finishes, which is t+4, t+6 or t+8.
- R8: An instruction whose destination is still pending from an earlier instruction stalls until that destination clears.
- R9: An integer result is forwarded, so a dependent instruction in the next cycle issues without a stall.
- R10: A writing integer-path instruction issued at cycle t produces a writeback pulse at t+3 with `wbUnit`=1 and its destination. A floating-point result is written back at t+latency when the port is free. An integer instruction with `writeDst`=0 produces no writeback.
- R11: At most one writeback occurs per cycle. The priority order is integer path, then adder, then multiplier. A floating-point result that loses arbitration is written back in the next cycle.
- R12: While a finished floating-point result waits for the write port, its unit accepts no new operation, and any instruction that writes that result's register stalls.
- R13: A source whose use flag is 0 causes no stall, whatever the pending state of the register it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction is present on the inputs |
| instClass | input | 3 | Operation class code |
| srcA | input | 5 | First source register |
| useA | input | 1 | First source is read |
| srcB | input | 5 | Second source register |
| useB | input | 1 | Second source is read |
| dst | input | 5 | Destination register |
| writeDst | input | 1 | Integer or load writes `dst` (floating-point classes always write it) |
| issue | output | 1 | Instruction leaves this cycle |
| stall | output | 1 | Instruction present but held |
| wbValid | output | 1 | Writeback pulse |
| wbReg | output | 5 | Register written back |
| wbUnit | output | 2 | Unit producing the writeback |

## Verification
The assertions assume that a stalled instruction stays unchanged on the inputs until it issues. They also assume that `instValid` is low while reset is held, and that a floating-point class always carries a meaningful `dst`. The bench drives each instruction through one task. That task holds every field constant from the cycle it is presented until the cycle `issue` is seen, and drops `instValid` only at a cycle boundary. Reset is applied at the start of each scenario with `instValid` low, so no instruction is half-presented across a reset.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_INT   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_FADD  = 3'd3,
    OP_FMULS = 3'd4,
    OP_FMULD = 3'd5
  } opClass_e;

  localparam logic [1:0] WB_NONE = 2'd0;
  localparam logic [1:0] WB_INT  = 2'd1;
  localparam logic [1:0] WB_ADD  = 2'd2;
  localparam logic [1:0] WB_MUL  = 2'd3;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic     pushInt;    // writing integer-path op enters the writeback delay line
    logic     startAdd;   // adder starts a new operation
    logic     startMul;   // multiplier starts a new operation
    logic     mulDouble;  // started multiply is double precision
    logic     wrDst;      // load the destination pending counter
    logic     grantAdd;   // adder result takes the write port
    logic     grantMul;   // multiplier result takes the write port
    opClass_e cls;        // class of the issuing instruction
  } ilkStrobe_t;

endpackage

// File: rtl/ilk_dpath.sv
module ilk_dpath
  import ilk_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int ADD_LAT  = 4,
  parameter int MULS_LAT = 6,
  parameter int MULD_LAT = 8,
  parameter int LOAD_USE = 3,
  localparam int AW   = $clog2(NREG),
  localparam int MAXA = (ADD_LAT > LOAD_USE) ? ADD_LAT : LOAD_USE,
  localparam int MAXM = (MULS_LAT > MULD_LAT) ? MULS_LAT : MULD_LAT,
  localparam int MAXL = (MAXA > MAXM) ? MAXA : MAXM,
  localparam int CW   = $clog2(MAXL)
) (
  input  logic            clk,
  input  logic            rst,
  input  ilkStrobe_t      st,
  input  logic [AW-1:0]   dst,
  output logic [NREG-1:0] pendNz,
  output logic            addRun,
  output logic            addDone,
  output logic [AW-1:0]   addDst,
  output logic            mulRun,
  output logic            mulDone,
  output logic [AW-1:0]   mulDst,
  output logic            intWbV,
  output logic            wbValid,
  output logic [AW-1:0]   wbReg,
  output logic [1:0]      wbUnit
);

  logic [CW-1:0] pendVal;
  logic [CW-1:0] addCnt;
  logic [CW-1:0] mulCnt;

  // Cycles until the written register may be read.
  always_comb begin
    case (st.cls)
      OP_LOAD:  pendVal = CW'(LOAD_USE - 1);
      OP_FADD:  pendVal = CW'(ADD_LAT - 1);
      OP_FMULS: pendVal = CW'(MULS_LAT - 1);
      OP_FMULD: pendVal = CW'(MULD_LAT - 1);
      default:  pendVal = '0;
    endcase
  end

  // One pending countdown for each architectural register.
  for (genvar g = 0; g < NREG; g++) begin : gPend
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                                 cnt <= '0;
      else if (st.wrDst && (dst == AW'(g)))    cnt <= pendVal;
      else if (cnt != '0)                      cnt <= cnt - 1'b1;
    end
    assign pendNz[g] = (cnt != '0);
  end

  // Adder occupancy.
  always_ff @(posedge clk) begin
    if (rst) begin
      addRun <= 1'b0;
      addCnt <= '0;
      addDst <= '0;
    end else if (st.startAdd) begin
      addRun <= 1'b1;
      addCnt <= CW'(ADD_LAT - 1);
      addDst <= dst;
    end else begin
      if (st.grantAdd)     addRun <= 1'b0;
      if (addCnt != '0)    addCnt <= addCnt - 1'b1;
    end
  end

  // Multiplier occupancy, latency picked by precision.
  always_ff @(posedge clk) begin
    if (rst) begin
      mulRun <= 1'b0;
      mulCnt <= '0;
      mulDst <= '0;
    end else if (st.startMul) begin
      mulRun <= 1'b1;
      mulCnt <= st.mulDouble ? CW'(MULD_LAT - 1) : CW'(MULS_LAT - 1);
      mulDst <= dst;
    end else begin
      if (st.grantMul)     mulRun <= 1'b0;
      if (mulCnt != '0)    mulCnt <= mulCnt - 1'b1;
    end
  end

  assign addDone = addRun && (addCnt == '0);
  assign mulDone = mulRun && (mulCnt == '0);

  // Integer-path writeback delay line: fixed depth, strictly in order.
  logic [LOAD_USE-1:0] ipV;
  logic [AW-1:0]       ipD [LOAD_USE];

  always_ff @(posedge clk) begin
    if (rst) ipV <= '0;
    else begin
      ipV[0] <= st.pushInt;
      for (int k = 1; k < LOAD_USE; k++) ipV[k] <= ipV[k-1];
    end
  end

  always_ff @(posedge clk) begin
    ipD[0] <= dst;
    for (int k = 1; k < LOAD_USE; k++) ipD[k] <= ipD[k-1];
  end

  assign intWbV = ipV[LOAD_USE-1];

  // Shared write port.
  always_comb begin
    wbValid = 1'b1;
    if (intWbV) begin
      wbReg  = ipD[LOAD_USE-1];
      wbUnit = WB_INT;
    end else if (st.grantAdd) begin
      wbReg  = addDst;
      wbUnit = WB_ADD;
    end else if (st.grantMul) begin
      wbReg  = mulDst;
      wbUnit = WB_MUL;
    end else begin
      wbValid = 1'b0;
      wbReg   = '0;
      wbUnit  = WB_NONE;
    end
  end

endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
  import ilk_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            rst,
  input  logic            instValid,
  input  logic [2:0]      instClass,
  input  logic [AW-1:0]   srcA,
  input  logic            useA,
  input  logic [AW-1:0]   srcB,
  input  logic            useB,
  input  logic [AW-1:0]   dst,
  input  logic            writeDst,
  input  logic [NREG-1:0] pendNz,
  input  logic            addRun,
  input  logic            addDone,
  input  logic [AW-1:0]   addDst,
  input  logic            mulRun,
  input  logic            mulDone,
  input  logic [AW-1:0]   mulDst,
  input  logic            intWbV,
  output ilkStrobe_t      st,
  output logic            issue,
  output logic            stall
);

  logic isInt, isLoad, isAdd, isMulS, isMulD, isMul, intPath, effWr;
  logic grantAdd, grantMul, addFree, mulFree;
  logic addHold, mulHold, rawHaz, wawHaz, unitHaz;

  assign isInt   = (instClass == OP_INT);
  assign isLoad  = (instClass == OP_LOAD);
  assign isAdd   = (instClass == OP_FADD);
  assign isMulS  = (instClass == OP_FMULS);
  assign isMulD  = (instClass == OP_FMULD);
  assign isMul   = isMulS || isMulD;
  assign intPath = isInt || isLoad;
  assign effWr   = intPath ? writeDst : (isAdd || isMul);

  // Write-port arbitration: integer path, then adder, then multiplier.
  assign grantAdd = addDone && !intWbV;
  assign grantMul = mulDone && !intWbV && !addDone;

  // A unit is free when idle, or when its result leaves this cycle.
  assign addFree = !addRun || grantAdd;
  assign mulFree = !mulRun || grantMul;

  // Results still owed to a register block later writers of it.
  assign addHold = addRun && (addDst == dst) && !grantAdd;
  assign mulHold = mulRun && (mulDst == dst) && !grantMul;

  assign rawHaz  = (useA && pendNz[srcA]) || (useB && pendNz[srcB]);
  assign wawHaz  = effWr && (pendNz[dst] || addHold || mulHold);
  assign unitHaz = (isAdd && !addFree) || (isMul && !mulFree);

  assign issue = instValid && !rst && !rawHaz && !wawHaz && !unitHaz;
  assign stall = instValid && !issue;

  always_comb begin
    st.pushInt   = issue && intPath && effWr;
    st.startAdd  = issue && isAdd;
    st.startMul  = issue && isMul;
    st.mulDouble = isMulD;
    st.wrDst     = issue && effWr;
    st.grantAdd  = grantAdd;
    st.grantMul  = grantMul;
    st.cls       = opClass_e'(instClass);
  end

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import ilk_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int ADD_LAT  = 4,
  parameter int MULS_LAT = 6,
  parameter int MULD_LAT = 8,
  parameter int LOAD_USE = 3,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instValid,
  input  logic [2:0]    instClass,
  input  logic [AW-1:0] srcA,
  input  logic          useA,
  input  logic [AW-1:0] srcB,
  input  logic          useB,
  input  logic [AW-1:0] dst,
  input  logic          writeDst,
  output logic          issue,
  output logic          stall,
  output logic          wbValid,
  output logic [AW-1:0] wbReg,
  output logic [1:0]    wbUnit
);

  ilkStrobe_t      st;
  logic [NREG-1:0] pendNz;
  logic            addRun, addDone, mulRun, mulDone, intWbV;
  logic [AW-1:0]   addDst, mulDst;

  ilk_ctrl #(.NREG(NREG)) uCtrl (
    .rst(rst), .instValid(instValid), .instClass(instClass),
    .srcA(srcA), .useA(useA), .srcB(srcB), .useB(useB),
    .dst(dst), .writeDst(writeDst), .pendNz(pendNz),
    .addRun(addRun), .addDone(addDone), .addDst(addDst),
    .mulRun(mulRun), .mulDone(mulDone), .mulDst(mulDst),
    .intWbV(intWbV), .st(st), .issue(issue), .stall(stall)
  );

  ilk_dpath #(
    .NREG(NREG), .ADD_LAT(ADD_LAT), .MULS_LAT(MULS_LAT),
    .MULD_LAT(MULD_LAT), .LOAD_USE(LOAD_USE)
  ) uDpath (
    .clk(clk), .rst(rst), .st(st), .dst(dst), .pendNz(pendNz),
    .addRun(addRun), .addDone(addDone), .addDst(addDst),
    .mulRun(mulRun), .mulDone(mulDone), .mulDst(mulDst),
    .intWbV(intWbV), .wbValid(wbValid), .wbReg(wbReg), .wbUnit(wbUnit)
  );

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker
  import ilk_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int ADD_LAT  = 4,
  parameter int MULS_LAT = 6,
  parameter int MULD_LAT = 8,
  parameter int LOAD_USE = 3,
  localparam int AW = $clog2(NREG),
  localparam int KW = $clog2(ADD_LAT + MULS_LAT + MULD_LAT + LOAD_USE + 2) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          instValid,
  input logic [2:0]    instClass,
  input logic [AW-1:0] srcA,
  input logic          useA,
  input logic [AW-1:0] srcB,
  input logic          useB,
  input logic [AW-1:0] dst,
  input logic          writeDst,
  input logic          issue,
  input logic          stall,
  input logic          wbValid,
  input logic [AW-1:0] wbReg,
  input logic [1:0]    wbUnit
);

  logic isAdd, isMul, isLd, isIntPath;
  assign isAdd     = (instClass == OP_FADD);
  assign isMul     = (instClass == OP_FMULS) || (instClass == OP_FMULD);
  assign isLd      = (instClass == OP_LOAD);
  assign isIntPath = isLd || (instClass == OP_INT);

  logic [KW-1:0] sinceAdd, sinceMul, needMul, sinceLd;
  logic          ldValid;
  logic [AW-1:0] ldDst;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceAdd <= KW'(ADD_LAT);
      sinceMul <= KW'(MULD_LAT);
      needMul  <= '0;
      sinceLd  <= KW'(LOAD_USE);
      ldValid  <= 1'b0;
      ldDst    <= '0;
    end else begin
      if (issue && isAdd)                      sinceAdd <= KW'(1);
      else if (sinceAdd < KW'(ADD_LAT))        sinceAdd <= sinceAdd + 1'b1;
      if (issue && isMul) begin
        sinceMul <= KW'(1);
        needMul  <= (instClass == OP_FMULD) ? KW'(MULD_LAT) : KW'(MULS_LAT);
      end else if (sinceMul < KW'(MULD_LAT))   sinceMul <= sinceMul + 1'b1;
      if (issue && isLd && writeDst) begin
        sinceLd <= KW'(1);
        ldValid <= 1'b1;
        ldDst   <= dst;
      end else if (sinceLd < KW'(LOAD_USE))    sinceLd <= sinceLd + 1'b1;
    end
  end

  // Expected integer-path writebacks, one per issued writing op.
  logic [LOAD_USE-1:0] expV;
  logic [AW-1:0]       expD [LOAD_USE];
  always_ff @(posedge clk) begin
    if (rst) expV <= '0;
    else begin
      expV[0] <= issue && isIntPath && writeDst;
      for (int k = 1; k < LOAD_USE; k++) expV[k] <= expV[k-1];
    end
  end
  always_ff @(posedge clk) begin
    expD[0] <= dst;
    for (int k = 1; k < LOAD_USE; k++) expD[k] <= expD[k-1];
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> (!issue && !stall))
    else $error("a_r2_idle_quiet");

  a_r2_stall_excl: assert property (@(posedge clk) disable iff (rst)
    stall |-> (instValid && !issue))
    else $error("a_r2_stall_excl");

  a_r3_add_occupancy: assert property (@(posedge clk) disable iff (rst)
    (issue && isAdd) |-> (sinceAdd >= KW'(ADD_LAT)))
    else $error("a_r3_add_occupancy");

  a_r4_mul_occupancy: assert property (@(posedge clk) disable iff (rst)
    (issue && isMul) |-> (sinceMul >= needMul))
    else $error("a_r4_mul_occupancy");

  a_r6_load_use: assert property (@(posedge clk) disable iff (rst)
    (issue && ldValid && ((useA && srcA == ldDst) || (useB && srcB == ldDst)))
      |-> (sinceLd >= KW'(LOAD_USE)))
    else $error("a_r6_load_use");

  a_r10_int_writeback: assert property (@(posedge clk) disable iff (rst)
    expV[LOAD_USE-1] |-> (wbValid && wbUnit == WB_INT && wbReg == expD[LOAD_USE-1]))
    else $error("a_r10_int_writeback");

  a_r11_unit_code: assert property (@(posedge clk) disable iff (rst)
    !wbValid |-> (wbUnit == WB_NONE))
    else $error("a_r11_unit_code");

endmodule

bind fp_issue_interlock ilk_checker #(
  .NREG(NREG), .ADD_LAT(ADD_LAT), .MULS_LAT(MULS_LAT),
  .MULD_LAT(MULD_LAT), .LOAD_USE(LOAD_USE)
) uChk (
  .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
  .srcA(srcA), .useA(useA), .srcB(srcB), .useB(useB), .dst(dst),
  .writeDst(writeDst), .issue(issue), .stall(stall), .wbValid(wbValid),
  .wbReg(wbReg), .wbUnit(wbUnit)
);

// File: tb/sim_fp_issue_interlock.sv
module sim_fp_issue_interlock;
  import ilk_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instValid = 1'b0;
  logic [2:0] instClass = 3'd0;
  logic [4:0] srcA = '0, srcB = '0, dst = '0;
  logic       useA = 1'b0, useB = 1'b0, writeDst = 1'b0;
  logic       issue, stall, wbValid;
  logic [4:0] wbReg;
  logic [1:0] wbUnit;

  int cyc = 0;
  int nChk = 0, nFail = 0;
  int wbN = 0;
  int wbCycA [64];
  int wbRegA [64];
  int wbUnitA[64];

  fp_issue_interlock u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .srcA(srcA), .useA(useA), .srcB(srcB), .useB(useB), .dst(dst),
    .writeDst(writeDst), .issue(issue), .stall(stall), .wbValid(wbValid),
    .wbReg(wbReg), .wbUnit(wbUnit)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && wbValid && wbN < 64) begin
      wbCycA[wbN]  = cyc;
      wbRegA[wbN]  = int'(wbReg);
      wbUnitA[wbN] = int'(wbUnit);
      wbN++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  task automatic doReset();
    @(negedge clk);
    instValid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wbN = 0;
  endtask

  // Present one instruction at a negedge and hold it until it issues.
  task automatic op(input logic [2:0] c, input int a, input bit ua,
                    input int b, input bit ub, input int d, input bit wd,
                    output int at, output int ns);
    instClass = c; srcA = a[4:0]; useA = ua; srcB = b[4:0]; useB = ub;
    dst = d[4:0]; writeDst = wd; instValid = 1'b1;
    at = -1; ns = 0;
    for (int k = 0; k < 60; k++) begin
      #1;
      if (issue) begin
        at = cyc;
        break;
      end
      if (stall) ns++;
      @(negedge clk);
    end
    @(negedge clk);
    instValid = 1'b0;
  endtask

  // Cycle of the first writeback of register r by unit u, -1 if none.
  function automatic int wbAt(input int r, input int u);
    for (int i = 0; i < wbN; i++)
      if (wbRegA[i] == r && wbUnitA[i] == u) return wbCycA[i];
    return -1;
  endfunction

  task automatic tReset();
    int at, ns;
    doReset();
    #1;
    chk("R1 wbValid after reset", int'(wbValid), 0);
    chk("R2 issue idle", int'(issue), 0);
    chk("R2 stall idle", int'(stall), 0);
    begin
      int base;
      base = cyc;
      op(OP_INT, 0, 0, 0, 0, 1, 1, at, ns);
      chk("R1 first int issue cycle", at, base);
      chk("R1 first int stalls", ns, 0);
    end
  endtask

  task automatic tAdder();
    int a0, at, ns;
    doReset();
    op(OP_FADD, 0, 0, 0, 0, 2, 1, a0, ns);
    op(OP_FADD, 5, 1, 6, 1, 3, 1, at, ns);
    chk("R3 second add issue", at - a0, 4);
    chk("R2 stall count add", ns, 3);
    repeat (12) @(negedge clk);
    chk("R10 add wb r2", wbAt(2, 2) - a0, 4);
    chk("R10 add wb r3", wbAt(3, 2) - a0, 8);
  endtask

  task automatic tMul();
    int m0, at, ns;
    doReset();
    op(OP_FMULS, 0, 0, 0, 0, 4, 1, m0, ns);
    op(OP_FMULD, 0, 0, 0, 0, 5, 1, at, ns);
    chk("R4 double after single", at - m0, 6);
    op(OP_FMULS, 0, 0, 0, 0, 6, 1, at, ns);
    chk("R4 single after double", at - m0, 14);
    repeat (4) @(negedge clk);
    chk("R10 mul wb r4", wbAt(4, 3) - m0, 6);
    chk("R10 mul wb r5", wbAt(5, 3) - m0, 14);
  endtask

  task automatic tOverlap();
    int i0, a1, a2, ns;
    doReset();
    op(OP_INT, 0, 0, 0, 0, 7, 1, i0, ns);
    op(OP_FADD, 1, 1, 2, 1, 8, 1, a1, ns);
    op(OP_FMULD, 3, 1, 4, 1, 9, 1, a2, ns);
    chk("R5 add after int", a1 - i0, 1);
    chk("R5 mul after add", a2 - i0, 2);
    repeat (12) @(negedge clk);
    chk("R10 int wb r7", wbAt(7, 1) - i0, 3);
    chk("R5 add wb r8", wbAt(8, 2) - i0, 5);
    chk("R5 mul wb r9", wbAt(9, 3) - i0, 10);
  endtask

  task automatic tLoadUse();
    int l0, at, ns;
    doReset();
    op(OP_LOAD, 0, 0, 0, 0, 10, 1, l0, ns);
    op(OP_INT, 10, 1, 0, 0, 11, 1, at, ns);
    chk("R6 reader of load issue", at - l0, 3);
    chk("R6 reader of load stalls", ns, 2);
    chk("R10 load wb r10", wbAt(10, 1) - l0, 3);
    op(OP_LOAD, 0, 0, 0, 0, 12, 1, l0, ns);
    op(OP_INT, 0, 0, 0, 0, 13, 1, at, ns);
    chk("R6 independent after load", at - l0, 1);
    op(OP_INT, 0, 0, 12, 1, 14, 1, at, ns);
    chk("R6 second-slot reader issue", at - l0, 3);
    chk("R6 second-slot reader stalls", ns, 1);
  endtask

  task automatic tFpRaw();
    int f0, at, ns;
    doReset();
    op(OP_FMULS, 0, 0, 0, 0, 15, 1, f0, ns);
    op(OP_INT, 0, 0, 15, 1, 1, 1, at, ns);
    chk("R7 reader of single mul", at - f0, 6);
    op(OP_FADD, 0, 0, 0, 0, 16, 1, f0, ns);
    op(OP_FMULS, 16, 1, 0, 0, 17, 1, at, ns);
    chk("R7 reader of add", at - f0, 4);
  endtask

  task automatic tWaw();
    int w0, at, ns;
    doReset();
    op(OP_FADD, 0, 0, 0, 0, 18, 1, w0, ns);
    op(OP_INT, 0, 0, 0, 0, 18, 1, at, ns);
    chk("R8 int overwriting add dst", at - w0, 4);
    op(OP_LOAD, 0, 0, 0, 0, 19, 1, w0, ns);
    op(OP_LOAD, 0, 0, 0, 0, 19, 1, at, ns);
    chk("R8 load overwriting load dst", at - w0, 3);
  endtask

  task automatic tIntFwd();
    int n0, at, ns;
    doReset();
    op(OP_INT, 0, 0, 0, 0, 20, 1, n0, ns);
    op(OP_INT, 20, 1, 20, 1, 21, 1, at, ns);
    chk("R9 dependent int issue", at - n0, 1);
    chk("R9 dependent int stalls", ns, 0);
  endtask

  task automatic tPriority();
    int c0, at, ns;
    doReset();
    op(OP_FMULS, 0, 0, 0, 0, 22, 1, c0, ns);
    op(OP_FADD, 0, 0, 0, 0, 23, 1, at, ns);
    op(OP_INT, 0, 0, 0, 0, 24, 1, at, ns);
    repeat (10) @(negedge clk);
    chk("R11 int wins port", wbAt(24, 1) - c0, 5);
    chk("R11 add delayed one cycle", wbAt(23, 2) - c0, 6);
    chk("R11 mul after add", wbAt(22, 3) - c0, 7);
    chk("R11 one wb per cycle count", wbN, 3);
  endtask

  task automatic tHeld();
    int c0, at, ns;
    doReset();
    op(OP_FADD, 0, 0, 0, 0, 25, 1, c0, ns);
    for (int r = 26; r < 30; r++) op(OP_INT, 0, 0, 0, 0, r, 1, at, ns);
    op(OP_FADD, 0, 0, 0, 0, 30, 1, at, ns);
    chk("R12 adder blocked by held result", at - c0, 8);
    repeat (2) @(negedge clk);
    chk("R12 held add wb", wbAt(25, 2) - c0, 8);
    doReset();
    op(OP_FADD, 0, 0, 0, 0, 25, 1, c0, ns);
    for (int r = 26; r < 30; r++) op(OP_INT, 0, 0, 0, 0, r, 1, at, ns);
    op(OP_INT, 0, 0, 0, 0, 25, 1, at, ns);
    chk("R12 writer of held dst", at - c0, 8);
    repeat (6) @(negedge clk);
    chk("R12 later int wb r25", wbAt(25, 1) - c0, 11);
  endtask

  task automatic tIgnore();
    int c0, at, ns;
    doReset();
    op(OP_LOAD, 0, 0, 0, 0, 1, 1, c0, ns);
    op(OP_INT, 1, 0, 1, 0, 2, 1, at, ns);
    chk("R13 unused sources ignored", at - c0, 1);
    op(OP_INT, 0, 0, 0, 0, 1, 0, at, ns);
    chk("R13 non-writing int ignores dst", at - c0, 2);
    repeat (6) @(negedge clk);
    chk("R10 no wb from non-writing int", wbN, 2);
    chk("R10 load wb r1", wbAt(1, 1) - c0, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 200000);
    summary();
    $finish;
  end

  initial begin
    tReset();
    tAdder();
    tMul();
    tOverlap();
    tLoadUse();
    tFpRaw();
    tWaw();
    tIntFwd();
    tPriority();
    tHeld();
    tIgnore();
    summary();
    $finish;
  end

endmodule